// File: doc/BRIEF.md
# Two-Wire Converter Readout Controller

This block is the device side of a readout link for a 24-bit converter. The link has only two pins. The host drives a serial clock in, and the device drives a single line that serves as both the ready flag and the data output. No command register exists. The host selects every action by how many clock pulses it sends after a result appears, or by how long it keeps the clock high.

The block receives a one-cycle strobe that carries a finished conversion result. The modulator and filter that produce the result are outside this block, so the strobe stands in for them. The block latches the result and pulls the shared line low. It then shifts the result out MSB first, one bit per rising clock edge. After the 24 data bits:

- The 25th pulse releases the line high.
- The 26th pulse asks for a self-calibration.
- Holding the clock high for a set time puts the block to sleep.

The serial clock is asynchronous to the fast system clock. It is resynchronised before any edge is decoded.

Top module: `adc2w_readout`

## Requirements
- R1: After reset `rdy_data` is 1, `sleep_o` is 0 and `cal_req` is 0. Rising `ser_clk` edges that arrive before the first result leave `rdy_data` at 1.
- R2: A `conv_valid` strobe latches `conv_result` and drives `rdy_data` to 0 on the next system-clock edge. The line then stays 0 for as long as `ser_clk` stays low.
- R3: A change of `ser_clk` takes effect on the third system-clock rising edge after the change. Each rising `ser_clk` edge drives the next result bit onto `rdy_data`. The first edge gives bit 23 (the MSB) and the 24th gives bit 0, in two's-complement order.
- R4: After the 24th edge, `rdy_data` holds bit 0. The 25th rising edge drives it to 1. It stays 1 for every later edge until the next strobe.
- R5: The falling edge of the 26th pulse issues a one-cycle `cal_req`. The line stays 1 until the next strobe.
- R6: A result is pending when a strobe has arrived and the block has neither slept nor started calibration since. While a result is pending, `ser_clk` held high for `HOLD_CYCLES` system clocks sets `sleep_o`, whatever number of bits has been read. While asleep, `rdy_data` is 1.
- R7: While asleep, strobes are ignored. `ser_clk` low clears `sleep_o`. The line stays 1 until the next strobe, which is read normally.
- R8: If the 26th pulse is held high long enough to sleep, no `cal_req` is issued at that point. A single `cal_req` is issued when the block wakes.
- R9: A strobe that arrives while a result is unread or partly read replaces the old result. The next rising edge gives bit 23 of the new result.
- R10: When a strobe and a decoded rising `ser_clk` edge fall in the same system cycle, the strobe wins. The new result is loaded, the line is driven 0 and the edge is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Asynchronous serial clock from the host |
| conv_valid | input | 1 | One-cycle strobe: a conversion result is available |
| conv_result | input | 24 | Two's-complement conversion result |
| rdy_data | output | 1 | Shared ready flag and serial data line |
| cal_req | output | 1 | One-cycle self-calibration request |
| sleep_o | output | 1 | High while the block is asleep |

## Verification
A result strobe and a decoded rising serial-clock edge can land in the same system cycle. This is the collision R10 resolves.

The bench provokes it by raising `ser_clk` in the middle of a partly read, all-ones result. It then pulses the strobe exactly on the third system edge, which is when the synchroniser presents the rising edge. The outcome is judged at the ports. The line must read 0 instead of the 1 the old result would have shifted. The next two pulses must return bits 23 and 22 of the new result.

// File: rtl/adc2w_pkg.sv
package adc2w_pkg;
  localparam int unsigned RESULT_W_DEF  = 24;
  localparam int unsigned HOLD_DEF      = 32;
  localparam int unsigned SYNC_DEF      = 2;
endpackage

// File: rtl/adc2w_sclk_sync.sv
module adc2w_sclk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] pipe;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= async_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= pipe[STAGES-1];
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~prev;
  assign fall = ~pipe[STAGES-1] & prev;
endmodule

// File: rtl/adc2w_hold_timer.sv
module adc2w_hold_timer #(
  parameter int unsigned LIMIT = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic level,
  output logic expired
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst || !enable || !level) count <= '0;
    else if (count != LIM)        count <= count + 1'b1;
  end

  assign expired = (count == LIM);
endmodule

// File: rtl/adc2w_shift_ctl.sv
module adc2w_shift_ctl #(
  parameter int unsigned WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_lvl,
  input  logic             ser_rise,
  input  logic             ser_fall,
  input  logic             hold_exp,
  input  logic             conv_valid,
  input  logic [WIDTH-1:0] conv_result,
  output logic             line_o,
  output logic             cal_o,
  output logic             asleep_o,
  output logic             pending_o
);
  localparam int unsigned CW = $clog2(WIDTH + 3);
  localparam logic [CW-1:0] LAST_BIT = CW'(WIDTH);
  localparam logic [CW-1:0] RELEASE  = CW'(WIDTH + 1);
  localparam logic [CW-1:0] CAL_CNT  = CW'(WIDTH + 2);

  logic [WIDTH-1:0] shreg;
  logic [CW-1:0]    cnt;
  logic             pending;
  logic             cal_arm;
  logic             cal_wake;
  logic             asleep;
  logic             line_q;
  logic             cal_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      cnt      <= '0;
      pending  <= 1'b0;
      cal_arm  <= 1'b0;
      cal_wake <= 1'b0;
      asleep   <= 1'b0;
      line_q   <= 1'b1;
      cal_q    <= 1'b0;
    end else begin
      cal_q <= 1'b0;
      if (asleep) begin
        if (!ser_lvl) begin
          asleep   <= 1'b0;
          cnt      <= '0;
          cal_q    <= cal_wake;
          cal_wake <= 1'b0;
        end
      end else if (hold_exp) begin
        asleep   <= 1'b1;
        line_q   <= 1'b1;
        pending  <= 1'b0;
        cal_wake <= cal_arm;
        cal_arm  <= 1'b0;
      end else if (conv_valid) begin
        shreg   <= conv_result;
        line_q  <= 1'b0;
        cnt     <= '0;
        pending <= 1'b1;
        cal_arm <= 1'b0;
      end else if (pending && ser_rise) begin
        if (cnt < LAST_BIT) begin
          line_q <= shreg[WIDTH-1];
          shreg  <= {shreg[WIDTH-2:0], 1'b0};
          cnt    <= cnt + 1'b1;
        end else if (cnt == LAST_BIT) begin
          line_q <= 1'b1;
          cnt    <= RELEASE;
        end else if (cnt == RELEASE) begin
          cnt     <= CAL_CNT;
          cal_arm <= 1'b1;
        end
      end else if (cal_arm && ser_fall) begin
        cal_q   <= 1'b1;
        cal_arm <= 1'b0;
        pending <= 1'b0;
      end
    end
  end

  assign line_o    = line_q;
  assign cal_o     = cal_q;
  assign asleep_o  = asleep;
  assign pending_o = pending & ~asleep;
endmodule

// File: rtl/adc2w_readout.sv
module adc2w_readout
  import adc2w_pkg::*;
#(
  parameter int unsigned WIDTH       = RESULT_W_DEF,
  parameter int unsigned HOLD_CYCLES = HOLD_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_clk,
  input  logic             conv_valid,
  input  logic [WIDTH-1:0] conv_result,
  output logic             rdy_data,
  output logic             cal_req,
  output logic             sleep_o
);
  logic ser_lvl;
  logic ser_rise;
  logic ser_fall;
  logic hold_exp;
  logic pending;

  adc2w_sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (ser_clk),
    .lvl      (ser_lvl),
    .rise     (ser_rise),
    .fall     (ser_fall)
  );

  adc2w_hold_timer #(.LIMIT(HOLD_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .enable  (pending),
    .level   (ser_lvl),
    .expired (hold_exp)
  );

  adc2w_shift_ctl #(.WIDTH(WIDTH)) u_ctl (
    .clk         (clk),
    .rst         (rst),
    .ser_lvl     (ser_lvl),
    .ser_rise    (ser_rise),
    .ser_fall    (ser_fall),
    .hold_exp    (hold_exp),
    .conv_valid  (conv_valid),
    .conv_result (conv_result),
    .line_o      (rdy_data),
    .cal_o       (cal_req),
    .asleep_o    (sleep_o),
    .pending_o   (pending)
  );
endmodule

// File: rtl/adc2w_readout_chk.sv
module adc2w_readout_chk (
  input logic clk,
  input logic rst,
  input logic ser_lvl,
  input logic hold_exp,
  input logic conv_valid,
  input logic rdy_data,
  input logic cal_req,
  input logic sleep_o
);
  // R5
  cal_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cal_req |=> !cal_req);

  // R6
  sleep_high_chk: assert property (@(posedge clk) disable iff (rst)
    sleep_o |-> rdy_data);

  // R6
  sleep_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sleep_o) |-> $past(hold_exp));

  // R7
  wake_chk: assert property (@(posedge clk) disable iff (rst)
    (sleep_o && !ser_lvl) |=> !sleep_o);

  // R7
  asleep_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (sleep_o && ser_lvl) |=> (sleep_o && rdy_data));

  // R2
  load_low_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_valid && !sleep_o && !hold_exp) |=> !rdy_data);
endmodule

bind adc2w_readout adc2w_readout_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .ser_lvl    (ser_lvl),
  .hold_exp   (hold_exp),
  .conv_valid (conv_valid),
  .rdy_data   (rdy_data),
  .cal_req    (cal_req),
  .sleep_o    (sleep_o)
);

// File: tb/adc2w_readout_bench.sv
module adc2w_readout_bench;
  localparam int W    = 24;
  localparam int HOLD = 32;

  logic         clk = 1'b0;
  logic         rst;
  logic         ser_clk;
  logic         conv_valid;
  logic [W-1:0] conv_result;
  logic         rdy_data;
  logic         cal_req;
  logic         sleep_o;

  int checks = 0;
  int fails  = 0;
  int cal_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  adc2w_readout #(.WIDTH(W), .HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) u_adc2w_readout (
    .clk         (clk),
    .rst         (rst),
    .ser_clk     (ser_clk),
    .conv_valid  (conv_valid),
    .conv_result (conv_result),
    .rdy_data    (rdy_data),
    .cal_req     (cal_req),
    .sleep_o     (sleep_o)
  );

  always @(posedge clk) if (!rst && cal_req) cal_cnt++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_bit(input logic [W-1:0] d, input int idx);
    return d[W-1-idx];
  endfunction

  task automatic strobe(input logic [W-1:0] d);
    @(negedge clk);
    conv_valid  = 1'b1;
    conv_result = d;
    @(negedge clk);
    conv_valid  = 1'b0;
  endtask

  task automatic pulse(output logic b);
    ser_clk = 1'b1;
    repeat (4) @(negedge clk);
    b = rdy_data;
    ser_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic b;
    logic [W-1:0] d;
    int c0;
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; ser_clk = 1'b0; conv_valid = 1'b0; conv_result = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset rdy_data", rdy_data, 1);
    chk("R1 reset sleep_o", sleep_o, 0);
    chk("R1 reset cal_req", cal_req, 0);
    for (int i = 0; i < 3; i++) begin
      pulse(b);
      chk("R1 pulse before data", b, 1);
    end

    // R2/R3/R4/R5 directed full read
    d = 24'hA5C31E;
    strobe(d);
    chk("R2 line low after strobe", rdy_data, 0);
    repeat (10) @(negedge clk);
    chk("R2 line stays low", rdy_data, 0);
    for (int i = 0; i < W; i++) begin
      pulse(b);
      chk("R3 serial bit", b, exp_bit(d, i));
    end
    repeat (6) @(negedge clk);
    chk("R4 holds last bit", rdy_data, d[0]);
    pulse(b);
    chk("R4 25th pulse releases", b, 1);
    c0 = cal_cnt;
    pulse(b);
    chk("R5 26th pulse line high", b, 1);
    chk("R5 calibration request", cal_cnt, c0 + 1);
    pulse(b);
    chk("R4 27th pulse stays high", b, 1);
    chk("R5 no extra calibration", cal_cnt, c0 + 1);

    // R9 random overwrite of partly read results
    for (int k = 0; k < 8; k++) begin
      int n;
      d = W'($urandom);
      n = 1 + int'($urandom % W);
      strobe(d);
      chk("R9 line low on new result", rdy_data, 0);
      for (int i = 0; i < n; i++) begin
        pulse(b);
        chk("R9 bit of newest result", b, exp_bit(d, i));
      end
    end

    // R6/R7 sleep after a partial read
    d = 24'h3C0F81;
    strobe(d);
    for (int i = 0; i < 5; i++) begin
      pulse(b);
      chk("R6 partial read bit", b, exp_bit(d, i));
    end
    c0 = cal_cnt;
    ser_clk = 1'b1;
    repeat (HOLD + 20) @(negedge clk);
    chk("R6 asleep", sleep_o, 1);
    chk("R6 line high asleep", rdy_data, 1);
    strobe(24'h000001);
    repeat (3) @(negedge clk);
    chk("R7 strobe ignored asleep", rdy_data, 1);
    ser_clk = 1'b0;
    repeat (6) @(negedge clk);
    chk("R7 awake", sleep_o, 0);
    chk("R7 line high after wake", rdy_data, 1);
    chk("R7 no calibration on plain wake", cal_cnt, c0);
    pulse(b);
    chk("R7 pulse after wake ignored", b, 1);
    d = 24'h812345;
    strobe(d);
    pulse(b);
    chk("R7 read after wake", b, exp_bit(d, 0));

    // R8 26th pulse held high
    d = W'($urandom);
    strobe(d);
    for (int i = 0; i < W + 1; i++) pulse(b);
    c0 = cal_cnt;
    ser_clk = 1'b1;
    repeat (HOLD + 20) @(negedge clk);
    chk("R8 asleep on held 26th", sleep_o, 1);
    chk("R8 no calibration while held", cal_cnt, c0);
    ser_clk = 1'b0;
    repeat (6) @(negedge clk);
    chk("R8 awake", sleep_o, 0);
    chk("R8 calibration on wake", cal_cnt, c0 + 1);

    // R10 strobe and rising edge in one cycle
    strobe(24'hFFFFFF);
    for (int i = 0; i < 3; i++) pulse(b);
    d = 24'h2AAAAA;
    ser_clk = 1'b1;
    @(negedge clk);
    @(negedge clk);
    conv_valid  = 1'b1;
    conv_result = d;
    @(negedge clk);
    conv_valid  = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 strobe wins over edge", rdy_data, 0);
    ser_clk = 1'b0;
    repeat (4) @(negedge clk);
    pulse(b);
    chk("R10 first bit of new result", b, exp_bit(d, 0));
    pulse(b);
    chk("R10 second bit of new result", b, exp_bit(d, 1));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule